// File: doc/BRIEF.md
# PHY-Link Control Bus Receiver

This block sits on the link side of a serial-bus PHY-link interface. It watches the 2-bit control bus and the 8-bit data bus that the PHY drives, and turns them into three kinds of event. A status transfer becomes a 16-bit status word, unpacked into named fields and flagged by a one-cycle valid pulse. Received packet bytes are packed into 32-bit quadlets and presented with a one-cycle write strobe. After the link has asked for the bus, the short code sequence that the PHY sends back is decoded as a grant or a refusal. The block only listens and never drives either bus.

The meaning of a control code depends on who owns the bus. While the PHY owns it, 00 is idle, 01 is status, 10 is receive and 11 is transmit. After a grant the link owns the bus, and its own codes (01 hold, 10 transmit, 11 unused) are ignored until the bus returns to idle. The link tells the block that it is waiting for an arbitration result through `req_pending_i`. It holds that input from the request until the outcome arrives, and drops it before the next packet.

Top module: `phy_link_rx`

## Requirements
- R1: After a synchronous reset (`rst_n` low), every output is 0.
- R2: A status transfer is 8 consecutive cycles of control code 01. Each cycle delivers two bits on `data_i[1:0]`, with `data_i[1]` the more significant. The first cycle carries status bits 15:14 and the rest follow in order. `data_i[7:2]` is ignored.
- R3: `stat_valid_o` pulses for exactly one cycle, on the clock after the eighth 01 cycle is sampled. The fields are then valid and are held until the next status word. The field positions are: bit 15 is `arb_gap_o`, bit 14 is `sub_gap_o`, bit 13 is `bus_reset_o`, bit 12 is `state_timeout_o`, bits 11:8 are `reg_addr_o` and bits 7:0 are `reg_data_o`.
- R4: If the code leaves 01 before the eighth status cycle, the transfer is abandoned. No `stat_valid_o` pulse follows.
- R5: While the PHY owns the bus and `req_pending_i` is low, each cycle of code 10 captures one `data_i` byte. Four bytes are packed MSB-first into a quadlet: the first byte goes into bits 31:24.
- R6: `q_we_o` pulses for one cycle, on the clock after each fourth byte is sampled, with the quadlet on `q_data_o`. `q_data_o` holds its value until the next quadlet.
- R7: A receive ends on the first cycle whose code is not 10. If 1 to 3 bytes of an unfinished quadlet are pending, they are dropped and `rx_err_o` pulses for one cycle on the next clock. Otherwise no error is raised.
- R8: With `req_pending_i` high, code 11 in one cycle followed by code 00 in the next pulses `arb_won_o` one clock after the 00 is sampled. If anything other than 00 follows the 11, no pulse is given.
- R9: With `req_pending_i` high, code 10 followed by code 00 pulses `arb_lost_o` one clock after the 00 is sampled. The 10 cycle captures no byte.
- R10: After a grant the link owns the bus. All codes are ignored, with no status, quadlet or error output, until a cycle of code 00 returns ownership to the PHY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_i | input | 2 | Control bus |
| data_i | input | 8 | Data bus |
| req_pending_i | input | 1 | Link has a bus request outstanding |
| stat_valid_o | output | 1 | One-cycle pulse: new status word |
| arb_gap_o | output | 1 | Status: arbitration reset gap |
| sub_gap_o | output | 1 | Status: subaction gap |
| bus_reset_o | output | 1 | Status: bus reset |
| state_timeout_o | output | 1 | Status: state timeout |
| reg_addr_o | output | 4 | Status: PHY register address |
| reg_data_o | output | 8 | Status: PHY register data |
| q_data_o | output | 32 | Received quadlet |
| q_we_o | output | 1 | One-cycle quadlet write strobe |
| rx_err_o | output | 1 | One-cycle pulse: partial quadlet dropped |
| arb_won_o | output | 1 | One-cycle pulse: bus granted |
| arb_lost_o | output | 1 | One-cycle pulse: bus refused |

## Verification
The properties assume that the PHY follows the code rules above. In particular, `req_pending_i` is held across the whole outcome sequence and is low before a receive packet begins. Under those assumptions, every output pulse can be traced back to the control codes of the one or two cycles before it. The bench drives only such sequences. It lowers `req_pending_i` in the cycle after `arb_lost_o`, before the refused bus's packet starts. Link-owned codes appear only after a grant and always end with an idle cycle.

// File: rtl/phy_link_rx.sv
module phy_link_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ctl_i,
  input  logic [7:0]  data_i,
  input  logic        req_pending_i,
  output logic        stat_valid_o,
  output logic        arb_gap_o,
  output logic        sub_gap_o,
  output logic        bus_reset_o,
  output logic        state_timeout_o,
  output logic [3:0]  reg_addr_o,
  output logic [7:0]  reg_data_o,
  output logic [31:0] q_data_o,
  output logic        q_we_o,
  output logic        rx_err_o,
  output logic        arb_won_o,
  output logic        arb_lost_o
);

  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_STAT = 2'b01;
  localparam logic [1:0] C_RECV = 2'b10;
  localparam logic [1:0] C_XMIT = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_STAT, S_RECV, S_WON, S_LOST, S_LINK} st_t;

  st_t         st;
  logic [2:0]  cnt;
  logic [15:0] sreg, stat_q;
  logic [31:0] qsh;

  wire [15:0] sreg_nx = {sreg[13:0], data_i[1:0]};
  wire [31:0] qsh_nx  = {qsh[23:0], data_i};

  assign arb_gap_o       = stat_q[15];
  assign sub_gap_o       = stat_q[14];
  assign bus_reset_o     = stat_q[13];
  assign state_timeout_o = stat_q[12];
  assign reg_addr_o      = stat_q[11:8];
  assign reg_data_o      = stat_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      sreg         <= '0;
      stat_q       <= '0;
      qsh          <= '0;
      q_data_o     <= '0;
      stat_valid_o <= 1'b0;
      q_we_o       <= 1'b0;
      rx_err_o     <= 1'b0;
      arb_won_o    <= 1'b0;
      arb_lost_o   <= 1'b0;
    end else begin
      stat_valid_o <= 1'b0;
      q_we_o       <= 1'b0;
      rx_err_o     <= 1'b0;
      arb_won_o    <= 1'b0;
      arb_lost_o   <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          case (ctl_i)
            C_STAT: begin
              sreg <= sreg_nx;
              cnt  <= 3'd1;
              st   <= S_STAT;
            end
            C_RECV: begin
              if (req_pending_i) st <= S_LOST;
              else begin
                qsh <= qsh_nx;
                cnt <= 3'd1;
                st  <= S_RECV;
              end
            end
            C_XMIT: if (req_pending_i) st <= S_WON;
            default: ;
          endcase
        end
        S_STAT: begin
          if (ctl_i == C_STAT) begin
            sreg <= sreg_nx;
            if (cnt == 3'd7) begin
              stat_q       <= sreg_nx;
              stat_valid_o <= 1'b1;
              cnt          <= '0;
              st           <= S_IDLE;
            end else cnt <= cnt + 3'd1;
          end else begin
            cnt <= '0;
            st  <= S_IDLE;
          end
        end
        S_RECV: begin
          if (ctl_i == C_RECV) begin
            qsh <= qsh_nx;
            if (cnt[1:0] == 2'd3) begin
              q_data_o <= qsh_nx;
              q_we_o   <= 1'b1;
              cnt      <= '0;
            end else cnt <= cnt + 3'd1;
          end else begin
            rx_err_o <= (cnt[1:0] != 2'd0);
            cnt      <= '0;
            st       <= S_IDLE;
          end
        end
        S_WON: begin
          if (ctl_i == C_IDLE) begin
            arb_won_o <= 1'b1;
            st        <= S_LINK;
          end else st <= S_IDLE;
        end
        S_LOST: begin
          arb_lost_o <= (ctl_i == C_IDLE);
          st         <= S_IDLE;
        end
        S_LINK: if (ctl_i == C_IDLE) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module phy_link_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_i,
  input logic       stat_valid_o,
  input logic       q_we_o,
  input logic       rx_err_o,
  input logic       arb_won_o,
  input logic       arb_lost_o
);

  // R3
  status_after_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid_o |-> $past(ctl_i) == 2'b01);

  // R6
  quadlet_after_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_we_o |-> $past(ctl_i) == 2'b10);

  // R7
  err_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> $past(ctl_i) != 2'b10);

  // R8
  won_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_won_o |-> ($past(ctl_i) == 2'b00 && $past(ctl_i, 2) == 2'b11));

  // R9
  lost_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> ($past(ctl_i) == 2'b00 && $past(ctl_i, 2) == 2'b10));

  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stat_valid_o, q_we_o, rx_err_o, arb_won_o, arb_lost_o}));

endmodule

bind phy_link_rx phy_link_rx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .stat_valid_o(stat_valid_o),
  .q_we_o(q_we_o), .rx_err_o(rx_err_o), .arb_won_o(arb_won_o),
  .arb_lost_o(arb_lost_o));

// File: tb/test_phy_link_rx.sv
`timescale 1ns/1ps
module test_phy_link_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctl = 2'b00;
  logic [7:0]  data = 8'h00;
  logic        req = 1'b0;
  logic        stat_valid, arb_gap, sub_gap, bus_reset, state_timeout;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_data;
  logic [31:0] q_data;
  logic        q_we, rx_err, arb_won, arb_lost;

  int checks = 0;
  int errors = 0;
  int seen_sv, seen_we, seen_err, seen_won, seen_lost;

  always #2.5 clk = ~clk;

  phy_link_rx i_phy_link_rx (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .data_i(data), .req_pending_i(req),
    .stat_valid_o(stat_valid), .arb_gap_o(arb_gap), .sub_gap_o(sub_gap),
    .bus_reset_o(bus_reset), .state_timeout_o(state_timeout),
    .reg_addr_o(reg_addr), .reg_data_o(reg_data), .q_data_o(q_data),
    .q_we_o(q_we), .rx_err_o(rx_err), .arb_won_o(arb_won), .arb_lost_o(arb_lost));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic clear_seen();
    seen_sv = 0; seen_we = 0; seen_err = 0; seen_won = 0; seen_lost = 0;
  endtask

  task automatic step(input logic [1:0] c, input logic [7:0] d);
    ctl = c;
    data = d;
    @(posedge clk);
    #1;
    seen_sv += int'(stat_valid); seen_we += int'(q_we); seen_err += int'(rx_err);
    seen_won += int'(arb_won); seen_lost += int'(arb_lost);
  endtask

  task automatic t_reset();
    check("R1 outputs after reset",
          {stat_valid, q_we, rx_err, arb_won, arb_lost, stat_valid, 26'd0}, 32'd0);
    check("R1 quadlet after reset", q_data, 32'd0);
    check("R1 status after reset",
          {arb_gap, sub_gap, bus_reset, state_timeout, reg_addr, reg_data}, 32'd0);
  endtask

  task automatic t_status(input logic [15:0] w);
    clear_seen();
    for (int i = 0; i < 8; i++) begin
      step(2'b01, {6'b101011, w[15-2*i -: 2]});
      if (i < 7) check("R3 no valid before eighth cycle", stat_valid, 1'b0);
    end
    check("R3 valid pulse", stat_valid, 1'b1);
    check("R2 status word",
          {16'd0, arb_gap, sub_gap, bus_reset, state_timeout, reg_addr, reg_data}, {16'd0, w});
    step(2'b00, 8'h00);
    check("R3 valid one cycle", stat_valid, 1'b0);
    check("R3 fields held", {16'd0, reg_addr, reg_data}, {20'd0, w[11:0]});
  endtask

  task automatic t_status_abort();
    clear_seen();
    for (int i = 0; i < 3; i++) step(2'b01, 8'hFF);
    for (int i = 0; i < 10; i++) step(2'b00, 8'h00);
    check("R4 no valid after abort", seen_sv, 0);
  endtask

  task automatic recv_quad(input logic [31:0] q, input string r);
    for (int i = 0; i < 4; i++) begin
      step(2'b10, q[31-8*i -: 8]);
      if (i < 3) check({r, " no strobe mid quadlet"}, q_we, 1'b0);
    end
    check({r, " strobe"}, q_we, 1'b1);
    check({r, " quadlet"}, q_data, q);
  endtask

  task automatic t_selfid(input logic [31:0] q);
    clear_seen();
    recv_quad(q, "R5 first");
    recv_quad(~q, "R6 second");
    step(2'b00, 8'h00);
    check("R6 strobe one cycle", q_we, 1'b0);
    check("R7 no error on aligned end", rx_err, 1'b0);
    check("R6 quadlet held", q_data, ~q);
  endtask

  task automatic t_ack_partial(input logic [3:0] code);
    clear_seen();
    recv_quad({code, ~code, 24'h0}, "R5 ack");
    step(2'b10, 8'hAA);
    step(2'b10, 8'hBB);
    step(2'b00, 8'h00);
    check("R7 error pulse", rx_err, 1'b1);
    check("R7 partial not written", seen_we, 1);
    step(2'b00, 8'h00);
    check("R7 error one cycle", rx_err, 1'b0);
  endtask

  task automatic t_won();
    clear_seen();
    req = 1'b1;
    step(2'b11, 8'h00);
    check("R8 no early won", arb_won, 1'b0);
    step(2'b00, 8'h00);
    check("R8 won pulse", arb_won, 1'b1);
    req = 1'b0;
    step(2'b01, 8'hFF);
    for (int i = 0; i < 9; i++) step(2'b10, 8'h5A);
    step(2'b01, 8'h03);
    step(2'b11, 8'h03);
    check("R10 link codes ignored", seen_sv + seen_we + seen_err, 0);
    step(2'b00, 8'h00);
    check("R10 no event on release", seen_sv + seen_we + seen_err, 0);
    recv_quad(32'hCAFE_0123, "R10 receive after release");
  endtask

  task automatic t_won_abort();
    clear_seen();
    req = 1'b1;
    step(2'b11, 8'h00);
    step(2'b01, 8'h00);
    step(2'b00, 8'h00);
    step(2'b00, 8'h00);
    req = 1'b0;
    check("R8 no won without idle", seen_won, 0);
  endtask

  task automatic t_lost();
    clear_seen();
    req = 1'b1;
    step(2'b10, 8'h77);
    step(2'b00, 8'h00);
    check("R9 lost pulse", arb_lost, 1'b1);
    req = 1'b0;
    step(2'b00, 8'h00);
    check("R9 lost one cycle", arb_lost, 1'b0);
    check("R9 refusal byte not captured", seen_we + seen_err, 0);
    recv_quad(32'h4013_57F2, "R9 packet after refusal");
    step(2'b00, 8'h00);
    check("R9 packet clean end", rx_err, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    step(2'b00, 8'h00);
    t_status(16'hA5C3);
    t_status(16'h5A3C);
    t_status_abort();
    t_selfid(32'h4123_4560);
    t_ack_partial(4'h1);
    t_won();
    t_won_abort();
    t_lost();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule